// File: doc/BRIEF.md
# Dataflow ALU Processing Element

This block is a coarse-grained processing element for a streaming array. It holds one configured operation and applies it to 32-bit data tokens. Each of its three operand inputs is a valid/ready channel. The element fires as soon as every operand that the operation needs is present. A result leaves on a valid/ready output channel. The result stays in an output buffer until downstream takes it, and while the buffer is occupied the element does not fire again. A separate two-bit event channel carries condition tokens: arithmetic overflow and counter termination.

Before streaming starts, a small write port sets up the element. Through it the opcode, the set of operands in use and the set of preloaded operands are chosen, and constant values are loaded into the preload registers. A preloaded operand is always available and consumes no tokens. The opcode set covers plain arithmetic and logic and three operations that go beyond a single two-input step: multiply-add, a signed two-way sort that emits two tokens, and a down-counter.

The control is a three-state machine. In `ST_RUN` no result is buffered. In `ST_HOLD` one result waits for downstream. In `ST_SORT2` the smaller sort value waits and the larger is held back behind it. The transitions are:
- `ST_RUN` goes to `ST_HOLD` when the element fires (or to `ST_SORT2` for a sort).
- `ST_HOLD` returns to `ST_RUN` when the result is taken and nothing new fires.
- `ST_HOLD` stays in `ST_HOLD` (or enters `ST_SORT2`) when a take and a new firing happen in the same cycle.
- `ST_SORT2` goes to `ST_HOLD` when the smaller value is taken, and the larger value moves into the buffer.

Top module: `stream_alu_cell`

## Requirements
- R1: After reset, out_valid and evt_valid are low. The element is set to opcode ADD with operands 0 and 1 in use and none preloaded, so in_ready reads 3'b011.
- R2: The element fires only when every operand that is in use and not preloaded holds a token. in_ready stays low for any operand that is unused or preloaded. An unused, non-preloaded operand reads as zero.
- R3: While out_valid is high and out_ready is low, out_data stays stable. Results leave in firing order with none lost or duplicated. A new firing can happen in the same cycle that the previous result is taken.
- R4: Opcode values (cfg_data[3:0]) are:
  - 0 ADD (a+b)
  - 1 SUB (a-b)
  - 2 AND
  - 3 OR
  - 4 XOR
  - 5 SHL (a shifted left by b[4:0])
  - 6 MADD
  - 7 SORT
  - 8 CNT
  - any other value passes operand a through.
- R5: MADD produces a*b+c in signed form, truncated to 32 bits. ADD, SUB and MADD set overflow (event bit 0) when the signed result does not fit in 32 bits.
- R6: SORT emits two tokens per firing: first the signed minimum of a and b, then the signed maximum. No other firing happens between them.
- R7: CNT loads from operand a when no count is running, producing a-1 (or 0 if a is 0). Each later firing decrements the count by one. The firing whose result is 0 sets termination (event bit 1) and ends the count, so the next firing reloads from a.
- R8: An event token (evt_flags bit 0 overflow, bit 1 termination) is issued only when a firing raises at least one flag. The token is held stable until evt_ready. Firing waits while an event token is pending and is not being taken.
- R9: A preloaded operand supplies its configured constant on every firing. Preload values are written with cfg_sel 1, 2 and 3 for operands 0, 1 and 2.
- R10: A configuration write (cfg_we) is accepted only when out_valid and evt_valid are both low; otherwise it has no effect. An accepted write clears all collected operand tokens and any running count. With cfg_sel 0, cfg_data[3:0] sets the opcode, [6:4] the in-use mask and [10:8] the preload mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0: control word, 1..3: preload value of operand 0..2 |
| cfg_data | input | 32 | Configuration write data |
| in_valid | input | 3 | Token present, one bit per operand |
| in_ready | output | 3 | Operand slot can take a token |
| in_data | input | 96 | Operand i on bits [32i+31:32i] |
| out_valid | output | 1 | Result token present |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 32 | Result token |
| evt_valid | output | 1 | Event token present |
| evt_ready | input | 1 | Downstream takes the event |
| evt_flags | output | 2 | Bit 0 overflow, bit 1 counter termination |

## Verification
The bench goes after these corner cases:
- **Back-to-back firing against a stalled output.** A design that overwrote its buffer would lose a result. One that fired while full would drop a token.
- **Sort pairs under stall.** Another firing slipping between the minimum and maximum would break their order.
- **Counter reload.** This covers start values 0 and 1 and the reload after termination, where an off-by-one would shift the event to the wrong token.
- **Overflow boundaries** of ADD and MADD, where a design that checked only the truncated sum would miss the flag.
- **Configuration write while a result is stalled.** It must be ignored; a design that accepted it would change the opcode mid-stream.
- **Tokens offered on unused or preloaded operands.** A design that took them would corrupt the result or hang the channel.

// File: rtl/sac_pkg.sv
package sac_pkg;

    localparam int N_OPND = 3;
    localparam int SEL_W  = $clog2(N_OPND + 1);
    localparam int EVT_W  = 2;
    localparam int EVT_OVF  = 0;
    localparam int EVT_TERM = 1;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_SHL  = 4'd5,
        OP_MADD = 4'd6,
        OP_SORT = 4'd7,
        OP_CNT  = 4'd8
    } opcode_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_HOLD  = 2'd1,
        ST_SORT2 = 2'd2
    } cell_state_e;

endpackage

// File: rtl/sac_operand_slot.sv
module sac_operand_slot #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         use_en,
    input  logic         pre_en,
    input  logic         pre_we,
    input  logic [W-1:0] pre_wdata,
    input  logic         tok_valid,
    output logic         tok_ready,
    input  logic [W-1:0] tok_data,
    input  logic         take,
    output logic         avail,
    output logic [W-1:0] value
);

    logic         full;
    logic [W-1:0] held;
    logic [W-1:0] pre_val;
    logic         wants_token;

    assign wants_token = use_en && !pre_en;
    assign tok_ready   = wants_token && (!full || take);
    assign avail       = !wants_token || full;

    always_comb begin
        if (pre_en) begin
            value = pre_val;
        end else if (use_en) begin
            value = held;
        end else begin
            value = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            held <= '0;
        end else if (clear) begin
            full <= 1'b0;
        end else if (tok_valid && tok_ready) begin
            full <= 1'b1;
            held <= tok_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_val <= '0;
        end else if (pre_we) begin
            pre_val <= pre_wdata;
        end
    end

endmodule

// File: rtl/sac_hold_reg.sv
module sac_hold_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         ready,
    output logic         valid,
    output logic [W-1:0] dout
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
            dout  <= '0;
        end else if (load) begin
            valid <= 1'b1;
            dout  <= din;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end

endmodule

// File: rtl/sac_alu.sv
module sac_alu
    import sac_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]       op,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic [W-1:0]     c,
    input  logic             cnt_run,
    input  logic [W-1:0]     cnt_val,
    output logic [W-1:0]     res,
    output logic [W-1:0]     res_hi,
    output logic [EVT_W-1:0] flags,
    output logic             cnt_run_n,
    output logic [W-1:0]     cnt_val_n
);

    localparam int SH_W  = $clog2(W);
    localparam int ACC_W = 2 * W + 2;

    logic signed [2*W-1:0]   prod;
    logic        [ACC_W-1:0] acc;
    logic        [W:0]       top_bits;
    logic        [W-1:0]     sum, dif, cnt_next;
    logic                    a_lt_b;

    assign sum      = a + b;
    assign dif      = a - b;
    assign prod     = $signed(a) * $signed(b);
    assign acc      = {{2{prod[2*W-1]}}, prod} + {{(W + 2){c[W-1]}}, c};
    assign top_bits = acc[ACC_W-1:W-1];
    assign a_lt_b   = $signed(a) < $signed(b);

    always_comb begin
        if (cnt_run) begin
            cnt_next = cnt_val - 1'b1;
        end else if (a == '0) begin
            cnt_next = '0;
        end else begin
            cnt_next = a - 1'b1;
        end
    end

    always_comb begin
        res       = '0;
        res_hi    = '0;
        flags     = '0;
        cnt_run_n = cnt_run;
        cnt_val_n = cnt_val;
        case (op)
            OP_ADD: begin
                res            = sum;
                flags[EVT_OVF] = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
            end
            OP_SUB: begin
                res            = dif;
                flags[EVT_OVF] = (a[W-1] != b[W-1]) && (dif[W-1] != a[W-1]);
            end
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_SHL: res = a << b[SH_W-1:0];
            OP_MADD: begin
                res            = acc[W-1:0];
                flags[EVT_OVF] = !((&top_bits) || (~|top_bits));
            end
            OP_SORT: begin
                res    = a_lt_b ? a : b;
                res_hi = a_lt_b ? b : a;
            end
            OP_CNT: begin
                res             = cnt_next;
                flags[EVT_TERM] = (cnt_next == '0);
                cnt_run_n       = (cnt_next != '0);
                cnt_val_n       = cnt_next;
            end
            default: res = a;
        endcase
    end

endmodule

// File: rtl/stream_alu_cell.sv
module stream_alu_cell
    import sac_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [SEL_W-1:0]         cfg_sel,
    input  logic [DATA_W-1:0]        cfg_data,
    input  logic [N_OPND-1:0]        in_valid,
    output logic [N_OPND-1:0]        in_ready,
    input  logic [N_OPND*DATA_W-1:0] in_data,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [DATA_W-1:0]        out_data,
    output logic                     evt_valid,
    input  logic                     evt_ready,
    output logic [EVT_W-1:0]         evt_flags
);

    cell_state_e state, state_n;

    logic [3:0]        cfg_op;
    logic [N_OPND-1:0] cfg_use, cfg_pre;
    logic [N_OPND-1:0] need_mask;
    logic [N_OPND-1:0] slot_avail;
    logic [DATA_W-1:0] opnd [N_OPND];

    logic              idle, cfg_acc, fire, out_room, evt_room, is_sort;
    logic              out_load;
    logic [DATA_W-1:0] out_din;
    logic [DATA_W-1:0] alu_res, alu_hi, sort_hi;
    logic [EVT_W-1:0]  alu_flags;
    logic              cnt_run, cnt_run_n;
    logic [DATA_W-1:0] cnt_val, cnt_val_n;

    assign need_mask = cfg_use & ~cfg_pre;
    assign idle      = (state == ST_RUN) && !evt_valid;
    assign cfg_acc   = cfg_we && idle;
    assign is_sort   = (cfg_op == OP_SORT);
    assign evt_room  = !evt_valid || evt_ready;
    assign fire      = (&slot_avail) && out_room && evt_room && !cfg_acc;

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_op  <= OP_ADD;
            cfg_use <= 3'b011;
            cfg_pre <= '0;
        end else if (cfg_acc && cfg_sel == '0) begin
            cfg_op  <= cfg_data[3:0];
            cfg_use <= cfg_data[6:4];
            cfg_pre <= cfg_data[10:8];
        end
    end

    // operand slots
    for (genvar i = 0; i < N_OPND; i++) begin : g_slot
        sac_operand_slot #(.W(DATA_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (cfg_acc),
            .use_en    (cfg_use[i]),
            .pre_en    (cfg_pre[i]),
            .pre_we    (cfg_acc && (cfg_sel == SEL_W'(i + 1))),
            .pre_wdata (cfg_data),
            .tok_valid (in_valid[i]),
            .tok_ready (in_ready[i]),
            .tok_data  (in_data[i*DATA_W +: DATA_W]),
            .take      (fire && need_mask[i]),
            .avail     (slot_avail[i]),
            .value     (opnd[i])
        );
    end

    sac_alu #(.W(DATA_W)) u_alu (
        .op        (cfg_op),
        .a         (opnd[0]),
        .b         (opnd[1]),
        .c         (opnd[2]),
        .cnt_run   (cnt_run),
        .cnt_val   (cnt_val),
        .res       (alu_res),
        .res_hi    (alu_hi),
        .flags     (alu_flags),
        .cnt_run_n (cnt_run_n),
        .cnt_val_n (cnt_val_n)
    );

    // counter and second sort value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_run <= 1'b0;
            cnt_val <= '0;
            sort_hi <= '0;
        end else if (cfg_acc) begin
            cnt_run <= 1'b0;
            cnt_val <= '0;
        end else if (fire) begin
            cnt_run <= cnt_run_n;
            cnt_val <= cnt_val_n;
            if (is_sort) begin
                sort_hi <= alu_hi;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= state_n;
        end
    end

    // next state and buffer control
    always_comb begin
        state_n  = state;
        out_room = 1'b0;
        out_load = 1'b0;
        out_din  = alu_res;
        unique case (state)
            ST_RUN: begin
                out_room = 1'b1;
                if (fire) begin
                    out_load = 1'b1;
                    state_n  = is_sort ? ST_SORT2 : ST_HOLD;
                end
            end
            ST_HOLD: begin
                out_room = out_ready;
                if (fire) begin
                    out_load = 1'b1;
                    state_n  = is_sort ? ST_SORT2 : ST_HOLD;
                end else if (out_ready) begin
                    state_n = ST_RUN;
                end
            end
            ST_SORT2: begin
                out_room = 1'b0;
                out_din  = sort_hi;
                if (out_ready) begin
                    out_load = 1'b1;
                    state_n  = ST_HOLD;
                end
            end
            default: state_n = ST_RUN;
        endcase
    end

    sac_hold_reg #(.W(DATA_W)) u_out_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (out_load),
        .din   (out_din),
        .ready (out_ready),
        .valid (out_valid),
        .dout  (out_data)
    );

    sac_hold_reg #(.W(EVT_W)) u_evt_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (fire && (|alu_flags)),
        .din   (alu_flags),
        .ready (evt_ready),
        .valid (evt_valid),
        .dout  (evt_flags)
    );

endmodule

// File: rtl/sac_cell_chk.sv
module sac_cell_chk
    import sac_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_OPND-1:0] in_ready,
    input logic [N_OPND-1:0] need_mask,
    input logic              cfg_acc,
    input logic [1:0]        state,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              evt_valid,
    input logic              evt_ready,
    input logic [EVT_W-1:0]  evt_flags
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !out_valid && !evt_valid);                          // R1

    AST_NO_READY_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready & ~need_mask) == '0);                                // R2

    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));   // R3

    AST_SORT_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SORT2) && out_ready |=> out_valid);               // R6

    AST_EVT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && !evt_ready |=> evt_valid && $stable(evt_flags));  // R8

    AST_EVT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> evt_flags != '0);                                // R8

    AST_CFG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_acc |-> !out_valid && !evt_valid);                         // R10

endmodule

bind stream_alu_cell sac_cell_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .need_mask (need_mask),
    .cfg_acc   (cfg_acc),
    .state     (state),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .evt_valid (evt_valid),
    .evt_ready (evt_ready),
    .evt_flags (evt_flags)
);

// File: tb/stream_alu_cell_bench.sv
module stream_alu_cell_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [W-1:0]  cfg_data = '0;
    logic [2:0]    in_valid = '0;
    logic [2:0]    in_ready;
    logic [3*W-1:0] in_data = '0;
    logic          out_valid, evt_valid;
    logic          out_ready = 1'b0, evt_ready = 1'b0;
    logic [W-1:0]  out_data;
    logic [1:0]    evt_flags;

    stream_alu_cell u_stream_alu_cell (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .evt_valid(evt_valid), .evt_ready(evt_ready),
        .evt_flags(evt_flags)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    // drive registers
    logic [2:0]   drv_v = '0;
    logic [W-1:0] drv_d [3];

    // reference model state
    logic [3:0]   m_op = 4'd0;
    logic [2:0]   m_use = 3'b011, m_pre = 3'b000;
    logic [W-1:0] m_pv [3];
    logic         m_run = 1'b0;
    logic [W-1:0] m_cnt = '0;
    logic [W-1:0] q0 [$], q1 [$], q2 [$];
    logic [W-1:0] exp_out [$];
    string        exp_tag [$];
    logic [1:0]   exp_evt [$];

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string op_tag(logic [3:0] op);
        case (op)
            4'd6:    return "R5 madd";
            4'd7:    return "R6 sort";
            4'd8:    return "R7 count";
            default: return "R4 op";
        endcase
    endfunction

    // one firing of the model
    task automatic model_fire(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
        logic [W-1:0] r;
        logic [1:0]   f;
        logic signed [2*W+1:0] big;
        f = 2'b00;
        case (m_op)
            4'd0: begin
                r = a + b;
                big = $signed(a) + $signed(b);
                f[0] = (big > 66'sh7fffffff) || (big < -66'sh80000000);
            end
            4'd1: begin
                r = a - b;
                big = $signed(a) - $signed(b);
                f[0] = (big > 66'sh7fffffff) || (big < -66'sh80000000);
            end
            4'd2: r = a & b;
            4'd3: r = a | b;
            4'd4: r = a ^ b;
            4'd5: r = a << b[4:0];
            4'd6: begin
                big = 66'($signed(a)) * 66'($signed(b)) + 66'($signed(c));
                r = big[W-1:0];
                f[0] = (big > 66'sh7fffffff) || (big < -66'sh80000000);
            end
            4'd7: begin
                r = ($signed(a) < $signed(b)) ? a : b;
                exp_out.push_back(r);
                exp_tag.push_back("R6 sort min");
                r = ($signed(a) < $signed(b)) ? b : a;
            end
            4'd8: begin
                if (!m_run) r = (a == 0) ? 32'd0 : a - 1;
                else        r = m_cnt - 1;
                m_cnt = r;
                m_run = (r != 0);
                f[1] = (r == 0);
            end
            default: r = a;
        endcase
        exp_out.push_back(r);
        exp_tag.push_back(m_op == 4'd7 ? "R6 sort max" : op_tag(m_op));
        if (f != 2'b00) exp_evt.push_back(f);
    endtask

    task automatic model_try();
        logic [2:0] need;
        logic [W-1:0] v [3];
        need = m_use & ~m_pre;
        while ((!need[0] || q0.size() > 0) && (!need[1] || q1.size() > 0) &&
               (!need[2] || q2.size() > 0) && need != 3'b000) begin
            for (int i = 0; i < 3; i++)
                v[i] = m_pre[i] ? m_pv[i] : 32'd0;
            if (need[0]) v[0] = q0.pop_front();
            if (need[1]) v[1] = q1.pop_front();
            if (need[2]) v[2] = q2.pop_front();
            model_fire(v[0], v[1], v[2]);
        end
    endtask

    // one cycle: drive at negedge, observe just before posedge
    task automatic step();
        logic idle;
        @(negedge clk);
        in_valid = drv_v;
        for (int i = 0; i < 3; i++) in_data[i*W +: W] = drv_d[i];
        #(CLK_PERIOD / 2 - 1);
        idle = !out_valid && !evt_valid;
        for (int i = 0; i < 3; i++) begin
            if (in_valid[i] && in_ready[i]) begin
                if (i == 0) q0.push_back(drv_d[0]);
                if (i == 1) q1.push_back(drv_d[1]);
                if (i == 2) q2.push_back(drv_d[2]);
                drv_v[i] = 1'b0;
            end
        end
        if (out_valid && out_ready) begin
            if (exp_out.size() == 0) chk("R3 unexpected result", out_data, 32'hdeadbeef);
            else chk(exp_tag.pop_front(), out_data, exp_out.pop_front());
        end
        if (evt_valid && evt_ready) begin
            if (exp_evt.size() == 0) chk("R8 unexpected event", 32'(evt_flags), 32'd0);
            else chk("R8 event flags", 32'(evt_flags), 32'(exp_evt.pop_front()));
        end
        if (cfg_we && idle) begin
            q0.delete(); q1.delete(); q2.delete();
            m_run = 1'b0;
            m_cnt = '0;
            if (cfg_sel == 0) begin
                m_op  = cfg_data[3:0];
                m_use = cfg_data[6:4];
                m_pre = cfg_data[10:8];
            end else begin
                m_pv[cfg_sel - 1] = cfg_data;
            end
        end
        model_try();
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
    endtask

    task automatic send(int i, logic [W-1:0] val);
        drv_v[i] = 1'b1;
        drv_d[i] = val;
        while (drv_v[i]) step();
    endtask

    task automatic drain();
        int quiet = 0;
        drv_v = '0;
        out_ready = 1'b1;
        evt_ready = 1'b1;
        while (quiet < 4) begin
            step();
            quiet = (out_valid || evt_valid) ? 0 : quiet + 1;
        end
    endtask

    task automatic cfg_write(logic [1:0] sel, logic [W-1:0] data);
        drain();
        cfg_sel  = sel;
        cfg_data = data;
        cfg_we   = 1'b1;
        step();
    endtask

    task automatic set_op(logic [3:0] op, logic [2:0] use_m, logic [2:0] pre_m);
        cfg_write(2'd0, {21'd0, pre_m, 1'b0, use_m, op});
    endtask

    function automatic logic [W-1:0] rnd_word();
        case ($urandom % 8)
            0: return 32'h7fffffff;
            1: return 32'h80000000;
            2: return 32'hffffffff;
            3: return $urandom % 4;
            default: return $urandom;
        endcase
    endfunction

    task automatic rnd_run(int cycles);
        for (int n = 0; n < cycles; n++) begin
            for (int i = 0; i < 3; i++) begin
                if (!drv_v[i] && ($urandom % 3 != 0)) begin
                    drv_v[i] = 1'b1;
                    drv_d[i] = (m_op == 4'd8) ? ($urandom % 6) : rnd_word();
                end
            end
            out_ready = ($urandom % 4) != 0;
            evt_ready = ($urandom % 3) != 0;
            step();
        end
        drain();
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin
            drv_d[i] = '0;
            m_pv[i] = '0;
        end
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid after reset", 32'(out_valid), 32'd0);
        chk("R1 evt_valid after reset", 32'(evt_valid), 32'd0);
        chk("R1 in_ready after reset", 32'(in_ready), 32'd3);

        // default ADD with overflow
        out_ready = 1'b1; evt_ready = 1'b1;
        send(0, 32'h7fffffff); send(1, 32'd1);
        send(0, 32'd20); send(1, 32'd22);
        drain();

        // stall: ignored configuration write, back-to-back results
        out_ready = 1'b0;
        send(0, 32'd5); send(1, 32'd7);
        step(); step();
        chk("R3 held result valid", 32'(out_valid), 32'd1);
        chk("R3 held result data", out_data, 32'd12);
        cfg_sel = 2'd0; cfg_data = 32'h0000_0031; cfg_we = 1'b1;
        step();
        send(0, 32'd10); send(1, 32'd3);
        step();
        chk("R3 data stable under stall", out_data, 32'd12);
        drain();
        chk("R10 ignored write keeps ADD", 32'(exp_out.size()), 32'd0);

        // unused operand reads zero and refuses tokens
        set_op(4'd0, 3'b001, 3'b000);
        drv_v[1] = 1'b1; drv_d[1] = 32'd99;
        step();
        chk("R2 unused operand not ready", 32'(in_ready[2:1]), 32'd0);
        send(0, 32'd41);
        drain();
        drv_v = '0;

        // preloaded operand
        cfg_write(2'd2, 32'd100);
        set_op(4'd0, 3'b011, 3'b010);
        step();
        chk("R9 preloaded operand not ready", 32'(in_ready[1]), 32'd0);
        send(0, 32'd5);
        rnd_run(200);

        // directed multiply-add and sort
        set_op(4'd6, 3'b111, 3'b000);
        send(0, 32'h10000); send(1, 32'h10000); send(2, 32'd0);
        send(0, 32'hffffffff); send(1, 32'hffffffff); send(2, 32'd5);
        drain();
        set_op(4'd7, 3'b011, 3'b000);
        out_ready = 1'b0;
        send(0, 32'hfffffffb); send(1, 32'd3);
        send(0, 32'd9); send(1, 32'd2);
        repeat (3) step();
        drain();

        // counter: start 3, then 0, then 1
        set_op(4'd8, 3'b001, 3'b000);
        out_ready = 1'b1; evt_ready = 1'b1;
        send(0, 32'd3); send(0, 32'd9); send(0, 32'd9);
        send(0, 32'd0); send(0, 32'd1); send(0, 32'd4);
        drain();

        // random sweeps over opcodes
        set_op(4'd0, 3'b011, 3'b000); rnd_run(400);
        set_op(4'd1, 3'b011, 3'b000); rnd_run(400);
        set_op(4'd2, 3'b011, 3'b000); rnd_run(200);
        set_op(4'd3, 3'b011, 3'b000); rnd_run(200);
        set_op(4'd4, 3'b011, 3'b000); rnd_run(200);
        set_op(4'd5, 3'b011, 3'b000); rnd_run(300);
        set_op(4'd6, 3'b111, 3'b000); rnd_run(400);
        set_op(4'd7, 3'b011, 3'b000); rnd_run(400);
        set_op(4'd8, 3'b001, 3'b000); rnd_run(400);
        set_op(4'd12, 3'b001, 3'b000); rnd_run(100);
        cfg_write(2'd3, 32'hfffffff0);
        set_op(4'd6, 3'b111, 3'b100); rnd_run(300);

        drain();
        chk("R3 no result lost", 32'(exp_out.size()), 32'd0);
        chk("R8 no event lost", 32'(exp_evt.size()), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule